// File: doc/BRIEF.md
# Period-Buffered PWM Channel

This block is a single pulse-width channel for motor drive. A counter advances by one on every clock while the channel runs. When the counter equals the period register it returns to zero. That wrap is the period boundary. At each boundary a completion flag is raised. In the same clock, the duty value that software left in a staging word is copied into one of two active duty registers. A select field in the staging word picks which one. Software can therefore prepare the next duty at any time in a period, and the new value only takes effect at the next boundary.

The output goes high at each boundary, as long as the duty value now active is not zero. It goes low in the clock where the counter reaches that duty value. A control field chooses which of the two duty registers drives the output.

A staging write in the clock right after a boundary has a defined side effect. The written value also lands at once in the active duty register that its own select field names. This overwrite does not touch the output level set at the boundary, so the rest of that period can come out with an unexpected duty. The block reproduces this behaviour on purpose.

An interrupt request follows the flag, gated by an enable bit. Software clears the flag with a read-then-write handshake.

Top module: `pwm_buf_chan`

## Requirements
- R1: After reset, every readable address returns 0 and both `pwm_o` and `irq_o` are low.
- R2: While control bit 0 (run) is 1, the counter (read at address 2) grows by one per clock, and in the clock after it equals the period register (address 1) it reads 0. While run is 0 the counter holds its value.
- R3: In the clock after a boundary (run=1 and counter equal to period), control bit 7 (flag) reads 1.
- R4: At a boundary, the low 10 bits of the staging word (address 3) are copied into duty register 0 (address 4) when staging bit 15 is 0, or into duty register 1 (address 5) when it is 1. The other duty register keeps its value.
- R5: Control bit 2 picks the active duty register (0 selects address 4, 1 selects address 5). At a boundary `pwm_o` goes high if the active duty value after that clock is nonzero, and low otherwise. In a later clock, `pwm_o` goes low when the counter moves to a value equal to the active duty, but only if that duty is below the period. So duty 0 gives a constant low output, and a duty at or above the period gives a constant high output.
- R6: A staging write in the clock right after a boundary also writes its low 10 bits into the duty register named by its own bit 15, in the same clock. `pwm_o` is not altered by that write.
- R7: A staging write at any other time changes only the staging word. The duty registers keep their values until the next boundary.
- R8: Writing control with bit 7 = 0 clears the flag only if control was read (strobe `rd_en`) with the flag at 1 since the last control write. Writing bit 7 = 1 never sets the flag. A boundary in the same clock as a clear leaves the flag at 1.
- R9: `irq_o` is high exactly when the flag is 1 and control bit 1 (interrupt enable) is 1.
- R10: Writes to the counter address and to the duty addresses are ignored.
- R11: When a staging write and a boundary fall in the same clock, the transfer uses the previous staging contents, and the staging word takes the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 period, 3 staging) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe, used only to arm the flag clear |
| rd_addr | input | 3 | Read address (0 control, 1 period, 2 counter, 3 staging, 4 and 5 duty) |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| pwm_o | output | 1 | Pulse-width output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 10-bit counter and two duty registers. Both transfer destinations, and the choice of which one drives the output, can therefore be exercised. It programs a period of 9, so each period lasts ten clocks. This brings many boundaries within reach in a short run. It also lets the bench place staging and control writes exactly on a boundary clock or on the clock after it. Duty values of 0, inside the period and above the period cover all three output shapes.

// File: rtl/pwm_buf_pkg.sv
`timescale 1ns/1ps
package pwm_buf_pkg;

  // widened type for comparisons that need one bit of headroom
  localparam int WIDE_W = 17;
  typedef logic [WIDE_W-1:0] wide_t;

  // register map (word addresses)
  localparam int ADR_CTRL  = 0;
  localparam int ADR_CYCLE = 1;
  localparam int ADR_COUNT = 2;
  localparam int ADR_BUF   = 3;
  localparam int ADR_DUTY0 = 4;

  // control word bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_IEN  = 1;
  localparam int CB_OSEL = 2;
  localparam int CB_FLAG = 7;

  // counter has reached the period value
  function automatic logic period_hit(wide_t cnt, wide_t cyc);
    return cnt == cyc;
  endfunction

  // output falls when the next count equals the duty and duty lies inside the period
  function automatic logic edge_drop(wide_t cnt, wide_t duty, wide_t cyc);
    return ((cnt + wide_t'(1)) == duty) && (duty < cyc);
  endfunction

  // flag update: set has priority over clear
  function automatic logic flag_after(logic cur, logic set, logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_buf_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              match,
  output logic              run,
  output logic              irq_en,
  output logic [SEL_W-1:0]  out_sel,
  output logic [CNT_W-1:0]  cycle_q,
  output logic [DATA_W-1:0] buf_q,
  output logic              flag_q,
  output logic              buf_wr,
  output logic              ctrl_wr
);

  logic cycle_wr;
  logic arm_q;
  logic flag_clr;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign cycle_wr = wr_en && (wr_addr == ADDR_W'(ADR_CYCLE));
  assign buf_wr   = wr_en && (wr_addr == ADDR_W'(ADR_BUF));
  assign flag_clr = ctrl_wr && !wr_data[CB_FLAG] && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      irq_en  <= 1'b0;
      out_sel <= '0;
    end else if (ctrl_wr) begin
      run     <= wr_data[CB_RUN];
      irq_en  <= wr_data[CB_IEN];
      out_sel <= wr_data[CB_OSEL +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycle_q <= '0;
    else if (cycle_wr) cycle_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (buf_wr) buf_q <= wr_data;
  end

  // arming: a control read that sees the flag at 1 enables the next clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else if (ctrl_wr) arm_q <= 1'b0;
    else if (rd_en && (rd_addr == ADDR_W'(ADR_CTRL)) && flag_q) arm_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else flag_q <= flag_after(flag_q, match, flag_clr);
  end

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter
  import pwm_buf_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cycle_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match
);

  assign match = run && period_hit(wide_t'(cnt_q), wide_t'(cycle_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (run) begin
      if (match) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_duty_bank.sv
`timescale 1ns/1ps
module pwm_duty_bank #(
  parameter int CNT_W    = 10,
  parameter int NUM_DUTY = 2,
  parameter int SEL_W    = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           match,
  input  logic [CNT_W-1:0]               buf_val,
  input  logic [SEL_W-1:0]               buf_sel,
  input  logic                           buf_wr,
  input  logic [CNT_W-1:0]               wr_val,
  input  logic [SEL_W-1:0]               wr_sel,
  output logic [NUM_DUTY-1:0][CNT_W-1:0] duty_q,
  output logic [NUM_DUTY-1:0][CNT_W-1:0] duty_d,
  output logic                           post_match,
  output logic                           contend
);

  // staging write landing in the clock right after a boundary
  assign contend = post_match && buf_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_match <= 1'b0;
    else post_match <= match;
  end

  for (genvar i = 0; i < NUM_DUTY; i++) begin : g_duty
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
      nxt = cur_q;
      if (match && (buf_sel == SEL_W'(i))) nxt = buf_val;
      if (contend && (wr_sel == SEL_W'(i))) nxt = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else cur_q <= nxt;
    end

    assign duty_q[i] = cur_q;
    assign duty_d[i] = nxt;
  end

endmodule

// File: rtl/pwm_out_gen.sv
`timescale 1ns/1ps
module pwm_out_gen
  import pwm_buf_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             match,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cycle_q,
  input  logic [CNT_W-1:0] duty_act,
  input  logic [CNT_W-1:0] duty_next_act,
  output logic             pwm_q
);

  logic drop;

  assign drop = edge_drop(wide_t'(cnt_q), wide_t'(duty_act), wide_t'(cycle_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else if (run) begin
      if (match) pwm_q <= (duty_next_act != '0);
      else if (drop) pwm_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_buf_chan.sv
`timescale 1ns/1ps
module pwm_buf_chan
  import pwm_buf_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int NUM_DUTY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_o,
  output logic              irq_o
);

  localparam int SEL_W   = (NUM_DUTY > 1) ? $clog2(NUM_DUTY) : 1;
  localparam int SEL_LSB = DATA_W - SEL_W;

  logic                           run;
  logic                           irq_en;
  logic [SEL_W-1:0]               out_sel;
  logic [CNT_W-1:0]               cycle_q;
  logic [DATA_W-1:0]              buf_q;
  logic                           flag_q;
  logic                           buf_wr;
  logic                           ctrl_wr;
  logic [CNT_W-1:0]               cnt_q;
  logic                           match;
  logic [NUM_DUTY-1:0][CNT_W-1:0] duty_q;
  logic [NUM_DUTY-1:0][CNT_W-1:0] duty_d;
  logic                           post_match;
  logic                           contend;
  logic [CNT_W-1:0]               duty_act;
  logic [CNT_W-1:0]               duty_next_act;
  logic [CNT_W-1:0]               buf_val;
  logic [SEL_W-1:0]               buf_sel;
  logic [CNT_W-1:0]               wr_val;
  logic [SEL_W-1:0]               wr_sel;

  assign buf_val = buf_q[CNT_W-1:0];
  assign buf_sel = buf_q[SEL_LSB +: SEL_W];
  assign wr_val  = wr_data[CNT_W-1:0];
  assign wr_sel  = wr_data[SEL_LSB +: SEL_W];

  pwm_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .match(match),
    .run(run), .irq_en(irq_en), .out_sel(out_sel), .cycle_q(cycle_q),
    .buf_q(buf_q), .flag_q(flag_q), .buf_wr(buf_wr), .ctrl_wr(ctrl_wr)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .cycle_q(cycle_q),
    .cnt_q(cnt_q), .match(match)
  );

  pwm_duty_bank #(
    .CNT_W(CNT_W), .NUM_DUTY(NUM_DUTY), .SEL_W(SEL_W)
  ) i_bank (
    .clk(clk), .rst_n(rst_n), .match(match), .buf_val(buf_val),
    .buf_sel(buf_sel), .buf_wr(buf_wr), .wr_val(wr_val), .wr_sel(wr_sel),
    .duty_q(duty_q), .duty_d(duty_d), .post_match(post_match),
    .contend(contend)
  );

  // active duty register, current and next-clock value
  always_comb begin
    duty_act      = '0;
    duty_next_act = '0;
    for (int i = 0; i < NUM_DUTY; i++) begin
      if (out_sel == SEL_W'(i)) begin
        duty_act      = duty_q[i];
        duty_next_act = duty_d[i];
      end
    end
  end

  pwm_out_gen #(.CNT_W(CNT_W)) i_out (
    .clk(clk), .rst_n(rst_n), .run(run), .match(match), .cnt_q(cnt_q),
    .cycle_q(cycle_q), .duty_act(duty_act), .duty_next_act(duty_next_act),
    .pwm_q(pwm_o)
  );

  assign irq_o = flag_q && irq_en;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADR_CTRL)) begin
      rd_data[CB_RUN]             = run;
      rd_data[CB_IEN]             = irq_en;
      rd_data[CB_OSEL +: SEL_W]   = out_sel;
      rd_data[CB_FLAG]            = flag_q;
    end
    if (rd_addr == ADDR_W'(ADR_CYCLE)) rd_data[CNT_W-1:0] = cycle_q;
    if (rd_addr == ADDR_W'(ADR_COUNT)) rd_data[CNT_W-1:0] = cnt_q;
    if (rd_addr == ADDR_W'(ADR_BUF))   rd_data = buf_q;
    for (int i = 0; i < NUM_DUTY; i++) begin
      if (rd_addr == ADDR_W'(ADR_DUTY0 + i)) rd_data[CNT_W-1:0] = duty_q[i];
    end
  end

endmodule

// File: rtl/pwm_buf_chan_chk.sv
`timescale 1ns/1ps
module pwm_buf_chan_chk #(
  parameter int CNT_W    = 10,
  parameter int NUM_DUTY = 2,
  parameter int SEL_W    = 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           run,
  input logic                           match,
  input logic                           contend,
  input logic [CNT_W-1:0]               wr_val,
  input logic [SEL_W-1:0]               wr_sel,
  input logic [CNT_W-1:0]               cnt_q,
  input logic                           flag_q,
  input logic                           ctrl_wr,
  input logic                           irq_o,
  input logic                           pwm_o,
  input logic [NUM_DUTY-1:0][CNT_W-1:0] duty_q
);

  logic             last_cont;
  logic [SEL_W-1:0] last_sel;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] picked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cont <= 1'b0;
      last_sel  <= '0;
      last_val  <= '0;
    end else begin
      last_cont <= contend;
      last_sel  <= wr_sel;
      last_val  <= wr_val;
    end
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_DUTY; i++)
      if (last_sel == SEL_W'(i)) picked = duty_q[i];
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  // R3
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);

  // R8
  flag_falls_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ctrl_wr));

  // R5
  pwm_rises_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> $past(match));

  // R6
  contention_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_cont |-> (picked == last_val));

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_q);

endmodule

bind pwm_buf_chan pwm_buf_chan_chk #(
  .CNT_W(CNT_W), .NUM_DUTY(NUM_DUTY), .SEL_W(SEL_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .match(match), .contend(contend),
  .wr_val(wr_val), .wr_sel(wr_sel), .cnt_q(cnt_q), .flag_q(flag_q),
  .ctrl_wr(ctrl_wr), .irq_o(irq_o), .pwm_o(pwm_o), .duty_q(duty_q)
);

// File: tb/test_pwm_buf_chan.sv
`timescale 1ns/1ps
module test_pwm_buf_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  pwm_buf_chan i_pwm_buf_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  int m_cnt, m_cyc, m_buf, m_pwm, m_flag, m_arm, m_run, m_ien, m_osel, m_post;
  int m_duty [2];

  function automatic int m_read(input int a);
    case (a)
      0: return m_run + 2 * m_ien + 4 * m_osel + 128 * m_flag;
      1: return m_cyc;
      2: return m_cnt;
      3: return m_buf;
      4: return m_duty[0];
      5: return m_duty[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cyc = 0; m_buf = 0; m_pwm = 0; m_flag = 0; m_arm = 0;
      m_run = 0; m_ien = 0; m_osel = 0; m_post = 0;
      m_duty[0] = 0; m_duty[1] = 0;
    end else begin
      int hit, bw, cw, wval, wsel, nd0, nd1, npwm, nflag, narm, ncnt, act, nact;
      int nd [2];
      hit  = (m_run == 1 && m_cnt == m_cyc) ? 1 : 0;
      bw   = (wr_en && wr_addr == 3) ? 1 : 0;
      cw   = (wr_en && wr_addr == 0) ? 1 : 0;
      wval = wr_data % 1024;
      wsel = wr_data / 32768;
      nd[0] = m_duty[0]; nd[1] = m_duty[1];
      if (hit == 1) nd[m_buf / 32768] = m_buf % 1024;
      if (m_post == 1 && bw == 1) nd[wsel] = wval;
      act  = m_duty[m_osel];
      nact = nd[m_osel];
      npwm = m_pwm;
      if (m_run == 1) begin
        if (hit == 1) npwm = (nact != 0) ? 1 : 0;
        else if (m_cnt + 1 == act && act < m_cyc) npwm = 0;
      end
      nflag = m_flag;
      if (hit == 1) nflag = 1;
      else if (cw == 1 && wr_data[7] == 1'b0 && m_arm == 1) nflag = 0;
      narm = m_arm;
      if (cw == 1) narm = 0;
      else if (rd_en && rd_addr == 0 && m_flag == 1) narm = 1;
      ncnt = m_cnt;
      if (m_run == 1) ncnt = (hit == 1) ? 0 : (m_cnt + 1) % 1024;
      if (cw == 1) begin
        m_run = wr_data[0]; m_ien = wr_data[1]; m_osel = wr_data[2];
      end
      if (wr_en && wr_addr == 1) m_cyc = wval;
      if (bw == 1) m_buf = wr_data;
      m_duty[0] = nd[0]; m_duty[1] = nd[1];
      m_pwm = npwm; m_flag = nflag; m_arm = narm; m_cnt = ncnt; m_post = hit;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 pwm_o vs model", int'(pwm_o), m_pwm);
      chk("R9 irq_o vs model", int'(irq_o), (m_flag == 1 && m_ien == 1) ? 1 : 0);
      chk("R2 rd_data vs model", int'(rd_data), m_read(int'(rd_addr)));
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[2:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic rd_arm();
    rd_addr = 3'd0; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  // returns in the clock just before a boundary edge
  task automatic wait_match();
    do tick(); while (!(m_run == 1 && m_cnt == m_cyc));
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_o) hi++;
      tick();
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, a, b;
    tick(); tick(); tick();
    // R1 reset state
    for (int k = 0; k < 6; k++) begin
      rd(k, v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset pwm_o", int'(pwm_o), 0);
    chk("R1 reset irq_o", int'(irq_o), 0);
    rst_n = 1'b1;
    tick();

    wr(1, 9);
    wr(3, 4);
    wr(0, 3);
    wait_match(); tick();
    rd(4, v); chk("R4 transfer to duty0", v, 4);
    rd(0, v); chk("R3 flag after boundary", (v >> 7) & 1, 1);
    rd(2, v); chk("R2 counter wrapped", v, 0);
    chk("R9 irq with enable", int'(irq_o), 1);
    count_high(10, v); chk("R5 high clocks for duty 4", v, 4);

    // R10 read-only addresses
    wr(2, 5); wr(4, 7); wr(5, 9);
    rd(4, v); chk("R10 duty0 write ignored", v, 4);
    rd(5, v); chk("R10 duty1 write ignored", v, 0);
    rd(2, v); chk("R10 counter write ignored", v, m_cnt);

    // R7 staging write mid-period
    wr(3, 2);
    rd(4, v); chk("R7 duty0 unchanged mid-period", v, 4);
    rd(3, v); chk("R7 staging updated", v, 2);
    wait_match(); tick();
    rd(4, v); chk("R4 duty0 after boundary", v, 2);

    // R4 select bit routes to duty1
    wr(3, 16'h8006);
    wait_match(); tick();
    rd(5, v); chk("R4 transfer to duty1", v, 6);
    rd(4, v); chk("R4 duty0 untouched by sel1", v, 2);

    // R6 contention overwrite, output not altered
    wait_match(); tick();
    chk("R5 pwm high at wrap", int'(pwm_o), 1);
    wr(3, 0);
    rd(4, v); chk("R6 contention wrote duty0", v, 0);
    count_high(9, v); chk("R6 output kept high after overwrite", v, 9);
    chk("R5 duty 0 after transfer gives low", int'(pwm_o), 0);

    wait_match(); tick();
    wr(3, 16'h8003);
    rd(5, v); chk("R6 contention wrote duty1", v, 3);
    rd(4, v); chk("R6 duty0 untouched", v, 0);

    // R5 duty above period, output from duty1
    wr(0, 7);
    wr(3, 16'h800C);
    wait_match(); tick();
    count_high(10, v); chk("R5 duty above period constant high", v, 10);
    wr(3, 16'h8000);
    wait_match(); tick();
    count_high(10, v); chk("R5 duty zero constant low", v, 0);

    // R11 staging write on the boundary clock
    wr(3, 16'h8005);
    wait_match();
    wr(3, 16'h8007);
    rd(5, v); chk("R11 transfer used old staging", v, 5);
    rd(3, v); chk("R11 staging took new value", v, 32768 + 7);

    // R8 clear handshake
    wait_match(); tick();
    wr(0, 7);
    rd(0, v); chk("R8 clear without read ignored", (v >> 7) & 1, 1);
    rd_arm();
    wr(0, 7);
    rd(0, v); chk("R8 clear after read", (v >> 7) & 1, 0);
    chk("R9 irq low after clear", int'(irq_o), 0);
    wr(0, 16'h0087);
    rd(0, v); chk("R8 writing 1 does not set", (v >> 7) & 1, 0);
    wait_match(); tick();
    rd_arm();
    wait_match();
    wr(0, 7);
    rd(0, v); chk("R8 set wins over clear", (v >> 7) & 1, 1);

    // R9 enable gating
    wr(0, 5);
    chk("R9 irq masked", int'(irq_o), 0);
    wr(0, 7);
    chk("R9 irq unmasked", int'(irq_o), 1);

    // R2 hold when stopped
    wr(0, 6);
    rd(2, a);
    for (int k = 0; k < 5; k++) tick();
    rd(2, b);
    chk("R2 counter holds when stopped", b, a);

    finish_run();
  end

endmodule